// File: doc/BRIEF.md
# Dual-View Floating-Point / Packed-Integer Register Bank

This block is an eight-entry register bank, 80 bits per entry, that two execution units share. The floating-point unit sees it as a circular stack. A 3-bit top pointer selects the current top entry. Operand indices are taken relative to that pointer, and push and pop strobes move it. The packed-integer (SIMD) unit sees the same storage as eight flat 64-bit registers, addressed directly by a 3-bit field and aliased onto the low 64 bits of each entry.

Each entry carries a 2-bit tag that classifies its contents. The eight tags are packed into a 16-bit tag word. A status word reports the top pointer and whether the bank is currently in the SIMD view. The bank tracks transitions between the two views on its own:
- The first SIMD write after floating-point activity marks every tag valid and resets the top pointer.
- A SIMD write forces the upper 16 bits of its target entry to all ones, so the stored value reads as a non-number in the floating-point view.
- A separate strobe marks every entry empty. It is meant for the end of a SIMD code section.

Reads are combinational. Every update is registered on the rising clock edge.

Top module: `fpsimd_regbank`

## Requirements
- R1: After reset, the tag word is all ones (every entry empty), the top pointer is 0, the SIMD flag is 0, and every entry holds zero.
- R2: Tags are encoded as valid=2'b00, zero=2'b01, special=2'b10 and empty=2'b11. The tag of physical entry i occupies tag-word bits [2i+1:2i]. The status word carries the top pointer in bits [2:0] and the SIMD flag in bit 15, with all other bits zero.
- R3: A floating-point write (push or indexed write) tags its entry as zero when all 80 bits are zero, as special when bits [78:64] are all ones, and as valid otherwise.
- R4: A push with the mode select low decrements the top pointer modulo 8 and writes the data into the entry at the new top.
- R5: A pop with the mode select low marks the entry at the current top as empty and increments the top pointer modulo 8. The entry's data is left unchanged.
- R6: In the floating-point view (mode select low), both the read index and the write index select physical entry (top + index) mod 8.
- R7: A SIMD write (write enable with the mode select high) addresses a physical entry directly by index. It stores the low 64 data bits and sets bits [79:64] of that entry to all ones.
- R8: A SIMD write made while the SIMD flag is 0 sets every tag to valid, resets the top pointer to 0 and sets the SIMD flag. A SIMD write made while the flag is already 1 keeps every tag valid and leaves the top pointer unchanged.
- R9: The clear strobe sets every tag to empty and clears the SIMD flag. It leaves the top pointer and all entry data unchanged.
- R10: A read with the mode select high returns the low 64 bits of the directly indexed entry, with bits [79:64] of the output forced to zero.
- R11: Within one cycle, clear has priority over push, push over pop, and pop over an indexed write. With the mode select high, push and pop strobes are ignored: the top pointer, the tags and the data do not change.
- R12: Any floating-point push, pop or indexed write clears the SIMD flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| view_simd_i | input | 1 | Mode select for this cycle's access: 0 = floating-point stack view, 1 = SIMD direct view |
| rd_idx_i | input | 3 | Read index (relative to the top pointer in the stack view, absolute in the SIMD view) |
| rd_data_o | output | 80 | Read data (upper 16 bits zero in the SIMD view) |
| wr_en_i | input | 1 | Indexed write strobe |
| wr_idx_i | input | 3 | Write index (relative or absolute, as for reads) |
| wr_data_i | input | 80 | Write data, also used as the push data |
| push_i | input | 1 | Stack push strobe |
| pop_i | input | 1 | Stack pop strobe |
| clr_tags_i | input | 1 | Mark every entry empty and leave the SIMD view |
| tag_word_o | output | 16 | Packed tags, two bits per physical entry |
| status_o | output | 16 | Top pointer and SIMD flag |

## Verification
The bench builds the bank with its default sizes: eight entries, 80-bit width and a 64-bit SIMD slice. At this size every pointer wrap is reachable within a few operations. A push from pointer 0 lands on entry 7, a pop from 7 returns to 0, and a relative index of 7 folds back past the end. Because the SIMD slice is narrower than the entry, both effects are visible at the ports: the forced upper bits after a SIMD write, and their masking on a SIMD-view read. Three specific test values drive the classifier into each of the zero, special and valid tags.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      TAG_VALID   = 2'b00,
      TAG_ZERO    = 2'b01,
      TAG_SPECIAL = 2'b10,
      TAG_EMPTY   = 2'b11
   } tag_e;
endpackage

// File: rtl/fsr_tag_classify.sv
module fsr_tag_classify #(
   parameter int WIDTH  = 80,
   parameter int MANT_W = 64
) (
   input  logic [WIDTH-1:0] data_i,
   output fsr_pkg::tag_e    tag_o
);
   localparam int EXP_W = WIDTH - 1 - MANT_W;

   initial begin
      assert (EXP_W >= 1) else $error("fsr_tag_classify: exponent field must be at least one bit");
   end

   logic [EXP_W-1:0] expo;
   assign expo = data_i[WIDTH-2:MANT_W];

   always_comb begin
      if (data_i == '0)      tag_o = fsr_pkg::TAG_ZERO;
      else if (&expo)        tag_o = fsr_pkg::TAG_SPECIAL;
      else                   tag_o = fsr_pkg::TAG_VALID;
   end
endmodule

// File: rtl/fsr_entry_store.sv
module fsr_entry_store #(
   parameter int ENTRIES = 8,
   parameter int WIDTH   = 80
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_i,
   input  logic [$clog2(ENTRIES)-1:0] widx_i,
   input  logic [WIDTH-1:0]           wdata_i,
   input  logic [$clog2(ENTRIES)-1:0] ridx_i,
   output logic [WIDTH-1:0]           rdata_o
);
   localparam int IDX_W = $clog2(ENTRIES);

   logic [WIDTH-1:0] ent [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [WIDTH-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               val_q <= '0;
         else if (we_i && widx_i == IDX_W'(i))     val_q <= wdata_i;
      end
      assign ent[i] = val_q;
   end

   assign rdata_o = ent[ridx_i];

   // R6: a granted write lands in the addressed entry
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ent[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/fpsimd_regbank.sv
module fpsimd_regbank #(
   parameter int ENTRIES = 8,
   parameter int WIDTH   = 80,
   parameter int SIMD_W  = 64,
   parameter int STAT_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       view_simd_i,
   input  logic [$clog2(ENTRIES)-1:0] rd_idx_i,
   output logic [WIDTH-1:0]           rd_data_o,
   input  logic                       wr_en_i,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
   input  logic [WIDTH-1:0]           wr_data_i,
   input  logic                       push_i,
   input  logic                       pop_i,
   input  logic                       clr_tags_i,
   output logic [2*ENTRIES-1:0]       tag_word_o,
   output logic [STAT_W-1:0]          status_o
);
   import fsr_pkg::*;

   localparam int PTR_W = $clog2(ENTRIES);
   localparam int TAG_W = 2 * ENTRIES;
   localparam int HI_W  = WIDTH - SIMD_W;
   localparam int PAD_W = STAT_W - 1 - PTR_W;

   initial begin
      assert ((1 << PTR_W) == ENTRIES) else $error("fpsimd_regbank: ENTRIES must be a power of two");
      assert (HI_W >= 2) else $error("fpsimd_regbank: WIDTH must exceed SIMD_W by at least two bits");
      assert (PAD_W >= 0) else $error("fpsimd_regbank: STAT_W too small for pointer and flag");
   end

   logic [PTR_W-1:0] top_q;
   logic [TAG_W-1:0] tag_q;
   logic             simd_q;

   // operation decode with fixed priority: clear > push > pop > write
   logic fp_push, fp_pop, fp_wr, simd_wr;
   assign fp_push = push_i && !view_simd_i && !clr_tags_i;
   assign fp_pop  = pop_i  && !view_simd_i && !clr_tags_i && !push_i;
   assign fp_wr   = wr_en_i && !view_simd_i && !clr_tags_i && !push_i && !pop_i;
   assign simd_wr = wr_en_i && view_simd_i && !clr_tags_i;

   logic [PTR_W-1:0] top_dec, top_inc, wr_rel, rd_rel;
   assign top_dec = top_q - PTR_W'(1);
   assign top_inc = top_q + PTR_W'(1);
   assign wr_rel  = top_q + wr_idx_i;
   assign rd_rel  = top_q + rd_idx_i;

   tag_e wr_class;
   fsr_tag_classify #(.WIDTH(WIDTH), .MANT_W(SIMD_W)) u_classify (
      .data_i (wr_data_i),
      .tag_o  (wr_class)
   );

   logic             st_we;
   logic [PTR_W-1:0] st_widx, st_ridx;
   logic [WIDTH-1:0] st_wdata, st_rdata;

   assign st_we    = fp_push || fp_wr || simd_wr;
   assign st_widx  = fp_push ? top_dec : (fp_wr ? wr_rel : wr_idx_i);
   assign st_wdata = simd_wr ? {{HI_W{1'b1}}, wr_data_i[SIMD_W-1:0]} : wr_data_i;
   assign st_ridx  = view_simd_i ? rd_idx_i : rd_rel;

   fsr_entry_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (st_we),
      .widx_i  (st_widx),
      .wdata_i (st_wdata),
      .ridx_i  (st_ridx),
      .rdata_o (st_rdata)
   );

   assign rd_data_o = view_simd_i ? {{HI_W{1'b0}}, st_rdata[SIMD_W-1:0]} : st_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q  <= '0;
         tag_q  <= '1;
         simd_q <= 1'b0;
      end else if (clr_tags_i) begin
         tag_q  <= '1;
         simd_q <= 1'b0;
      end else if (simd_wr) begin
         if (!simd_q) begin
            tag_q <= '0;
            top_q <= '0;
         end else begin
            tag_q[2*wr_idx_i +: 2] <= TAG_VALID;
         end
         simd_q <= 1'b1;
      end else if (fp_push) begin
         tag_q[2*top_dec +: 2] <= wr_class;
         top_q  <= top_dec;
         simd_q <= 1'b0;
      end else if (fp_pop) begin
         tag_q[2*top_q +: 2] <= TAG_EMPTY;
         top_q  <= top_inc;
         simd_q <= 1'b0;
      end else if (fp_wr) begin
         tag_q[2*wr_rel +: 2] <= wr_class;
         simd_q <= 1'b0;
      end
   end

   assign tag_word_o = tag_q;
   if (PAD_W > 0) begin : g_stat_pad
      assign status_o = {simd_q, {PAD_W{1'b0}}, top_q};
   end else begin : g_stat_tight
      assign status_o = {simd_q, top_q};
   end

   // R4: push moves the pointer down by one
   a_r4_push_top: assert property (@(posedge clk) disable iff (!rst_n)
      fp_push |=> top_q == $past(top_q) - PTR_W'(1));

   // R5: pop empties the old top
   a_r5_pop_tag: assert property (@(posedge clk) disable iff (!rst_n)
      fp_pop |=> tag_q[2*$past(top_q) +: 2] == TAG_EMPTY);

   // R8: entering the SIMD view validates every tag and resets the pointer
   a_r8_enter_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (simd_wr && !simd_q) |=> (tag_q == '0) && (top_q == '0) && simd_q);

   // R9: clear empties every tag and leaves the SIMD view
   a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr_tags_i |=> (tag_q == '1) && !simd_q && $stable(top_q));

   // R11: stack strobes in the SIMD view change nothing
   a_r11_simd_stack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (view_simd_i && (push_i || pop_i) && !wr_en_i && !clr_tags_i)
         |=> $stable(top_q) && $stable(tag_q) && $stable(simd_q));

   // R12: a floating-point operation leaves the SIMD view
   a_r12_fp_leaves_simd: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_push || fp_pop || fp_wr) |=> !simd_q);
endmodule

// File: tb/fpsimd_regbank_test.sv
`timescale 1ns/1ps
module fpsimd_regbank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        view_simd_i = 1'b0;
   logic [2:0]  rd_idx_i = '0;
   logic [79:0] rd_data_o;
   logic        wr_en_i = 1'b0;
   logic [2:0]  wr_idx_i = '0;
   logic [79:0] wr_data_i = '0;
   logic        push_i = 1'b0;
   logic        pop_i = 1'b0;
   logic        clr_tags_i = 1'b0;
   logic [15:0] tag_word_o;
   logic [15:0] status_o;

   int checks = 0;
   int fails  = 0;

   fpsimd_regbank uut (
      .clk(clk), .rst_n(rst_n), .view_simd_i(view_simd_i),
      .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .push_i(push_i), .pop_i(pop_i), .clr_tags_i(clr_tags_i),
      .tag_word_o(tag_word_o), .status_o(status_o)
   );

   always #10 clk = ~clk;

   // vector: cmd(2) 0=write 1=push 2=pop 3=clear | simd(1) | idx(3) | data(80) | exp tag(16) | exp status(16)
   localparam int NV = 11;
   localparam logic [117:0] VEC [NV] = '{
      {2'd1, 1'b0, 3'd0, 80'h3FFF_8000_0000_0000_0000, 16'h3FFF, 16'h0007}, // R4 R3 valid
      {2'd1, 1'b0, 3'd0, 80'h0000_0000_0000_0000_0000, 16'h1FFF, 16'h0006}, // R3 zero
      {2'd1, 1'b0, 3'd0, 80'h7FFF_C000_0000_0000_0000, 16'h1BFF, 16'h0005}, // R3 special
      {2'd0, 1'b0, 3'd1, 80'h4000_0000_0000_0000_0123, 16'h0BFF, 16'h0005}, // R6 rel write
      {2'd2, 1'b0, 3'd0, 80'h0,                        16'h0FFF, 16'h0006}, // R5
      {2'd2, 1'b0, 3'd0, 80'h0,                        16'h3FFF, 16'h0007}, // R5
      {2'd0, 1'b1, 3'd2, 80'hAAAA_1234_5678_9ABC_DEF0, 16'h0000, 16'h8000}, // R8 enter
      {2'd0, 1'b1, 3'd3, 80'h0000_0BAD_F00D_0000_0001, 16'h0000, 16'h8000}, // R8 stay
      {2'd1, 1'b0, 3'd0, 80'h0,                        16'h4000, 16'h0007}, // R12
      {2'd3, 1'b0, 3'd0, 80'h0,                        16'hFFFF, 16'h0007}, // R9
      {2'd2, 1'b0, 3'd0, 80'h0,                        16'hFFFF, 16'h0000}  // R5 wrap
   };

   task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic p, input logic po, input logic w, input logic m,
                       input logic cl, input logic [2:0] idx, input logic [79:0] d);
      push_i = p; pop_i = po; wr_en_i = w; view_simd_i = m; clr_tags_i = cl;
      wr_idx_i = idx; wr_data_i = d;
      @(posedge clk);
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0; wr_en_i = 1'b0; clr_tags_i = 1'b0; view_simd_i = 1'b0;
   endtask

   task automatic rd(input logic m, input logic [2:0] idx, input string req, input logic [79:0] exp);
      view_simd_i = m; rd_idx_i = idx;
      #1;
      chk(req, rd_data_o, exp);
      view_simd_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tag word", {64'h0, tag_word_o}, 80'hFFFF);
      chk("R1 status",   {64'h0, status_o},   80'h0);
      rd(1'b0, 3'd4, "R1 data", 80'h0);

      for (int i = 0; i < NV; i++) begin
         logic [117:0] v;
         v = VEC[i];
         case (v[117:116])
            2'd0: step(1'b0, 1'b0, 1'b1, v[115], 1'b0, v[114:112], v[111:32]);
            2'd1: step(1'b1, 1'b0, 1'b0, v[115], 1'b0, v[114:112], v[111:32]);
            2'd2: step(1'b0, 1'b1, 1'b0, v[115], 1'b0, v[114:112], v[111:32]);
            default: step(1'b0, 1'b0, 1'b0, v[115], 1'b1, v[114:112], v[111:32]);
         endcase
         chk($sformatf("R2 R3 R4 R5 R8 R9 R12 vec%0d tag", i), {64'h0, tag_word_o}, {64'h0, v[31:16]});
         chk($sformatf("R2 vec%0d status", i), {64'h0, status_o}, {64'h0, v[15:0]});
      end

      // top is 0 here; data persists across the clear
      rd(1'b0, 3'd6, "R6 relative read", 80'h4000_0000_0000_0000_0123);
      rd(1'b0, 3'd2, "R7 upper forced", 80'hFFFF_1234_5678_9ABC_DEF0);
      rd(1'b1, 3'd3, "R10 simd read", 80'h0000_0BAD_F00D_0000_0001);
      rd(1'b1, 3'd2, "R10 simd mask", 80'h0000_1234_5678_9ABC_DEF0);

      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 80'h1);
      chk("R4 wrap status", {64'h0, status_o}, 80'h7);
      chk("R3 valid tag", {64'h0, tag_word_o}, 80'h3FFF);
      rd(1'b0, 3'd0, "R4 push data", 80'h1);
      rd(1'b0, 3'd7, "R6 index wrap", 80'h4000_0000_0000_0000_0123);

      // R11 push beats pop
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 80'h0);
      chk("R11 push over pop status", {64'h0, status_o}, 80'h6);
      chk("R11 push over pop tag", {64'h0, tag_word_o}, 80'h1FFF);

      // R11 clear beats push: no write at entry 5, pointer stays
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 80'h5);
      chk("R11 clear over push status", {64'h0, status_o}, 80'h6);
      chk("R9 clear tag", {64'h0, tag_word_o}, 80'hFFFF);
      rd(1'b0, 3'd7, "R11 clear blocks push data", 80'h7FFF_C000_0000_0000_0000);

      // R11 stack strobes ignored in SIMD view
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 80'h9);
      chk("R11 simd push ignored status", {64'h0, status_o}, 80'h6);
      rd(1'b0, 3'd7, "R11 simd push ignored data", 80'h7FFF_C000_0000_0000_0000);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 80'h0);
      chk("R11 simd pop ignored status", {64'h0, status_o}, 80'h6);
      chk("R11 simd pop ignored tag", {64'h0, tag_word_o}, 80'hFFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule